// File: doc/BRIEF.md
# Per-Channel Sample Offset and Gain Trim

This block is a streaming correction stage placed after the decimation output of a multi-channel sigma-delta converter. Each incoming sample carries a channel index. For that channel the block removes a programmable zero error and then applies a programmable gain. The corrected sample leaves the block two clock cycles later, with its channel index and a valid strobe.

Every channel has its own pair of coefficients. Both coefficients are 24 bits wide and are loaded through a narrow register write port, one upper part and one lower part at a time. The coefficients are held in volatile storage and return to neutral values on reset. The correction cannot be switched off. With neutral coefficients the block passes samples through unchanged.

Top module: `trim_top`

## Requirements
- R1: After reset `out_valid` is low, and every channel holds offset 0x000000 and gain 0x800000, so any sample leaves the block unchanged.
- R2: For a sample x on channel c, the output is sat(round((x − off[c]) × gain[c] / 2^23)). Here x and off are 24-bit two's complement and gain is 24-bit unsigned with LSB weight 2^-23.
- R3: The subtraction x − off is formed at 25 bits and never wraps. For example, x = 0x7FFFFF with off = 0x800000 and gain = 0x200000 yields 0x400000.
- R4: Rounding is half-up, toward +infinity on ties: +1.5→2, −1.5→−1, +0.5→1, −0.5→0.
- R5: Results above 0x7FFFFF give 0x7FFFFF, and results below −2^23 give 0x800000.
- R6: A gain of 0x000000 forces the output to zero for any input and offset.
- R7: Coefficients are per channel. Writing one channel's coefficients does not change results on other channels.
- R8: Write address `wr_addr` = {channel, sel}, where sel sits in bits [1:0]. The sel codes are 0 = offset upper bits [23:8], 1 = offset lower bits [7:0], 2 = gain upper bits [23:8] and 3 = gain lower bits [7:0]. Lower parts use `wr_data[7:0]`.
- R9: A write of an upper part alone has no effect on results. The full 24-bit value takes effect only when the matching lower part is written.
- R10: An input presented with `in_valid` high at a rising edge appears on `out_valid`/`out_data` after exactly two rising edges, for one cycle, and `out_ch` equals the input channel. Back-to-back samples stream at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Coefficient register write strobe |
| wr_addr | input | 4 | {channel, part select} |
| wr_data | input | 16 | Coefficient part data |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | 2 | Input channel index |
| in_data | input | 24 | Input sample, two's complement |
| out_valid | output | 1 | Corrected sample strobe |
| out_ch | output | 2 | Channel index of the corrected sample |
| out_data | output | 24 | Corrected sample, two's complement |

## Verification
A wrong stored coefficient shows up on the first sample of the affected channel. It appears two cycles later as a value that differs from the reference formula. Because each scenario programs coefficients and then sends samples on every channel, a leak between channels or a premature commit after an upper-part write shows up on the next sample sent. A pipeline valid or channel tag that is lost or duplicated shows up at once as an `out_valid` pulse in the wrong cycle. Rounding and saturation faults show only on the tie and extreme inputs, so those inputs are sent explicitly.

// File: rtl/trim_pkg.sv
package trim_pkg;

  // part select in the low address bits of the coefficient write port
  typedef enum logic [1:0] {
    SEL_OFF_HI  = 2'd0,
    SEL_OFF_LO  = 2'd1,
    SEL_GAIN_HI = 2'd2,
    SEL_GAIN_LO = 2'd3
  } coef_sel_e;

endpackage

// File: rtl/trim_coef_bank.sv
module trim_coef_bank
  import trim_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 24,
  parameter int WR_W   = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LO_W  = DW - WR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  coef_sel_e       wr_sel,
  input  logic [WR_W-1:0] wr_data,
  input  logic [CH_W-1:0] rd_ch,
  output logic [DW-1:0]   rd_off,
  output logic [DW-1:0]   rd_gain
);

  localparam logic [DW-1:0] UNITY = {1'b1, {(DW-1){1'b0}}};

  logic [NUM_CH-1:0][DW-1:0]   off_q;
  logic [NUM_CH-1:0][DW-1:0]   gain_q;
  logic [NUM_CH-1:0][WR_W-1:0] off_stg_q;
  logic [NUM_CH-1:0][WR_W-1:0] gain_stg_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        off_q[c]      <= '0;
        gain_q[c]     <= UNITY;
        off_stg_q[c]  <= '0;
        gain_stg_q[c] <= UNITY[DW-1:LO_W];
      end else if (hit) begin
        case (wr_sel)
          SEL_OFF_HI:  off_stg_q[c]  <= wr_data;
          SEL_OFF_LO:  off_q[c]      <= {off_stg_q[c], wr_data[LO_W-1:0]};
          SEL_GAIN_HI: gain_stg_q[c] <= wr_data;
          SEL_GAIN_LO: gain_q[c]     <= {gain_stg_q[c], wr_data[LO_W-1:0]};
          default: ;
        endcase
      end
    end
  end

  assign rd_off  = off_q[rd_ch];
  assign rd_gain = gain_q[rd_ch];

  // R9
  commit_only_on_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_sel == SEL_OFF_LO || wr_sel == SEL_GAIN_LO))
    |=> ($stable(off_q) && $stable(gain_q)));

endmodule

// File: rtl/trim_datapath.sv
module trim_datapath #(
  parameter int DW     = 24,
  parameter int CH_W   = 2,
  parameter int FRAC   = 23,
  localparam int EW    = DW + 1,
  localparam int PW    = 2 * EW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [CH_W-1:0] in_ch,
  input  logic [DW-1:0]   in_data,
  input  logic [DW-1:0]   coef_off,
  input  logic [DW-1:0]   coef_gain,
  output logic            out_valid,
  output logic [CH_W-1:0] out_ch,
  output logic [DW-1:0]   out_data
);

  localparam logic signed [PW-1:0] RND_K = {{(PW-1){1'b0}}, 1'b1} << (FRAC - 1);
  localparam logic signed [PW-1:0] MAX_V = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MIN_V = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // stage 1: widened difference and captured gain
  logic                 s1_valid;
  logic [CH_W-1:0]      s1_ch;
  logic signed [EW-1:0] s1_diff;
  logic [DW-1:0]        s1_gain;
  logic signed [EW-1:0] diff_w;

  assign diff_w = $signed({in_data[DW-1], in_data}) - $signed({coef_off[DW-1], coef_off});

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_ch    <= '0;
      s1_diff  <= '0;
      s1_gain  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ch   <= in_ch;
        s1_diff <= diff_w;
        s1_gain <= coef_gain;
      end
    end
  end

  // stage 2: scale, round half-up, saturate
  logic signed [PW-1:0] prod_w;
  logic signed [PW-1:0] rnd_w;
  logic signed [PW-1:0] shf_w;
  logic [DW-1:0]        sat_w;

  assign prod_w = s1_diff * $signed({1'b0, s1_gain});
  assign rnd_w  = prod_w + RND_K;
  assign shf_w  = rnd_w >>> FRAC;

  always_comb begin
    if (shf_w > MAX_V)      sat_w = MAX_V[DW-1:0];
    else if (shf_w < MIN_V) sat_w = MIN_V[DW-1:0];
    else                    sat_w = shf_w[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_ch   <= s1_ch;
        out_data <= sat_w;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);

  // R6
  zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_gain == '0) |=> (out_data == '0));

  // R5
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_diff[EW-1]) |=> !out_data[DW-1]);

endmodule

// File: rtl/trim_top.sv
module trim_top
  import trim_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DW       = 24,
  parameter int WR_W     = 16,
  parameter int FRAC     = 23,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int ADDR_W  = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output logic [DW-1:0]     out_data
);

  logic [DW-1:0] cur_off;
  logic [DW-1:0] cur_gain;
  coef_sel_e     sel;

  assign sel = coef_sel_e'(wr_addr[1:0]);

  trim_coef_bank #(
    .NUM_CH (NUM_CH),
    .DW     (DW),
    .WR_W   (WR_W)
  ) i_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_ch   (wr_addr[ADDR_W-1:2]),
    .wr_sel  (sel),
    .wr_data (wr_data),
    .rd_ch   (in_ch),
    .rd_off  (cur_off),
    .rd_gain (cur_gain)
  );

  trim_datapath #(
    .DW   (DW),
    .CH_W (CH_W),
    .FRAC (FRAC)
  ) i_path (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ch     (in_ch),
    .in_data   (in_data),
    .coef_off  (cur_off),
    .coef_gain (cur_gain),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_data  (out_data)
  );

endmodule

// File: tb/test_trim_top.sv
module test_trim_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_ch = '0;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic [1:0]  out_ch;
  logic [23:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [23:0] m_off  [4];
  logic [23:0] m_gain [4];

  always #2.5 clk = ~clk;

  trim_top i_trim_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  function automatic logic [23:0] model(logic [23:0] x, logic [23:0] o, logic [23:0] g);
    longint d, p, r;
    d = longint'($signed(x)) - longint'($signed(o));
    p = d * longint'({40'd0, g});
    r = (p + 64'sd4194304) >>> 23;
    if (r > 64'sd8388607) r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r[23:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R8: upper part then lower part, sel in addr[1:0]
  task automatic set_coef(int ch, bit is_gain, logic [23:0] v);
    logic [1:0] c = 2'(ch);
    wr_reg({c, is_gain ? 2'd2 : 2'd0}, v[23:8]);
    wr_reg({c, is_gain ? 2'd3 : 2'd1}, {8'd0, v[7:0]});
    if (is_gain) m_gain[ch] = v; else m_off[ch] = v;
  endtask

  // one sample, checks latency and value (R10 plus caller's tag)
  task automatic send(string req, int ch, logic [23:0] x);
    logic [23:0] exp = model(x, m_off[ch], m_gain[ch]);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 2'(ch); in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 valid early", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R10 valid on time", 32'(out_valid), 32'd1);
    chk("R10 channel tag", 32'(out_ch), 32'(ch));
    chk(req, 32'(out_data), 32'(exp));
    @(negedge clk);
    chk("R10 single pulse", 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    send("R1 ch0 passthrough", 0, 24'h123456);
    send("R1 ch3 negative passthrough", 3, 24'hFEDCBA);
    send("R1 ch2 max passthrough", 2, 24'h7FFFFF);
    send("R1 ch1 min passthrough", 1, 24'h800000);
  endtask

  task automatic t_basic;
    set_coef(1, 1'b0, 24'h000100);
    send("R2 offset ch1", 1, 24'h001000);
    chk("R2 offset value", 32'(model(24'h001000, 24'h000100, 24'h800000)), 32'h000F00);
    set_coef(2, 1'b1, 24'hC00000);
    send("R2 gain 1.5 ch2", 2, 24'd1000);
    set_coef(2, 1'b0, 24'hFFFFF0);
    send("R2 offset then gain ch2", 2, 24'hFFFF00);
    send("R7 ch0 untouched", 0, 24'h00ABCD);
    send("R7 ch3 untouched", 3, 24'h3FFFFF);
  endtask

  task automatic t_wide_diff;
    set_coef(0, 1'b0, 24'h800000);
    set_coef(0, 1'b1, 24'h200000);
    send("R3 no wrap", 0, 24'h7FFFFF);
    chk("R3 reference", 32'(model(24'h7FFFFF, 24'h800000, 24'h200000)), 32'h400000);
    set_coef(0, 1'b0, 24'h000000);
  endtask

  task automatic t_round;
    set_coef(0, 1'b1, 24'h400000);
    send("R4 +1.5 to 2", 0, 24'd3);
    send("R4 -1.5 to -1", 0, 24'hFFFFFD);
    send("R4 +0.5 to 1", 0, 24'd1);
    send("R4 -0.5 to 0", 0, 24'hFFFFFF);
  endtask

  task automatic t_sat;
    set_coef(0, 1'b1, 24'hFFFFFF);
    send("R5 positive clip", 0, 24'h7FFFFF);
    send("R5 negative clip", 0, 24'h800000);
    set_coef(0, 1'b1, 24'h800000);
    set_coef(0, 1'b0, 24'h7FFFFF);
    send("R5 offset driven negative clip", 0, 24'h800000);
    set_coef(0, 1'b0, 24'h800000);
    send("R5 offset driven positive clip", 0, 24'h000001);
    set_coef(0, 1'b0, 24'h000000);
  endtask

  task automatic t_zero_gain;
    set_coef(3, 1'b1, 24'h000000);
    set_coef(3, 1'b0, 24'h123456);
    send("R6 zero gain", 3, 24'h7FFFFF);
    send("R6 zero gain negative", 3, 24'h800000);
    send("R7 ch1 keeps its own offset", 1, 24'h000100);
  endtask

  task automatic t_half_write;
    wr_reg({2'd2, 2'd2}, 16'h0000);
    send("R9 gain upper alone ignored", 2, 24'd1000);
    wr_reg({2'd2, 2'd0}, 16'h0010);
    send("R9 offset upper alone ignored", 2, 24'd1000);
    wr_reg({2'd2, 2'd3}, 16'h0000);
    m_gain[2] = 24'h000000;
    send("R9 gain commit on lower", 2, 24'd1000);
    wr_reg({2'd2, 2'd1}, 16'h0020);
    m_off[2] = 24'h001020;
    set_coef(2, 1'b1, 24'h800000);
    send("R9 offset commit on lower", 2, 24'h002000);
  endtask

  task automatic t_stream;
    logic [23:0] xs [6] = '{24'h000010, 24'hFFFF00, 24'h7FFFFF, 24'h800000, 24'h000003, 24'h012345};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int k = i - 2;
        chk("R10 stream valid", 32'(out_valid), 32'd1);
        chk("R10 stream channel", 32'(out_ch), 32'(k % 4));
        chk("R10 stream data", 32'(out_data), 32'(model(xs[k], m_off[k % 4], m_gain[k % 4])));
      end
      if (i < 6) begin
        in_valid = 1'b1; in_ch = 2'(i % 4); in_data = xs[i];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R10 stream end", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_off[c] = 24'h000000;
      m_gain[c] = 24'h800000;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_wide_diff();
    t_round();
    t_sat();
    t_zero_gain();
    t_half_write();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule